// File: doc/BRIEF.md
# Activity-List Replacement Selector

This block picks which entry of a small associative store should be given up next. It keeps a recency rank for every entry. Rank 0 marks the entry used least recently, and the top rank marks the one used most recently. When an entry is touched, it takes the top rank. Every entry that outranked it moves down one step. Entries ranked below it keep their rank. The ranks therefore always form a permutation of 0..N-1, and the entry holding rank 0 is the least recently used one.

Several independent lists can be instantiated side by side, one per set of a set-associative store. A reference carries a set number and an entry number, and it changes only the list of that set. A separate query port names a set, and the block returns that set's victim combinationally from the current ranks. A query issued in the same cycle as a reference therefore sees the ranks as they were before the update.

Top module: `lru_activity_list`

## Requirements
- R1: After synchronous reset, entry i of every set holds rank i, so the reported victim of every set is entry 0.
- R2: On a reference, the referenced entry of the addressed set takes rank N-1 at the next clock edge.
- R3: On a reference to an entry with old rank r, every entry of that set with rank above r drops by exactly one, and every entry with rank below r is unchanged.
- R4: Referencing the entry that already holds rank N-1 leaves that set's whole list unchanged.
- R5: `victim_idx` is the index of the entry with the lowest rank in the set selected by `query_set`.
- R6: When a reference and a query occur in the same cycle, `victim_idx` reflects the ranks before that reference takes effect.
- R7: A reference to one set never changes the ranks or the victim of any other set.
- R8: The ranks of each set are a permutation of 0..N-1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A reference is present this cycle |
| ref_set | input | SET_W | Set addressed by the reference |
| ref_idx | input | IDX_W = log2(N_ENTRIES) | Entry referenced within that set |
| query_set | input | SET_W | Set whose victim is reported |
| victim_idx | output | IDX_W | Entry holding the lowest rank in `query_set` |

## Verification
The embedded properties check on every cycle that each list stays a permutation and that the reported victim holds rank 0. They also check that a referenced entry reaches the top rank, that entries outranking it step down by one while lower entries hold, and that touching the top-ranked entry freezes the list. Only the bench's scenarios can show that a query in the same cycle as a reference returns the old victim, that other sets remain untouched, and that long reference streams produce the exact victim sequence that a reference model predicts.

// File: rtl/lru_pkg.sv
package lru_pkg;

    localparam int DEF_ENTRIES = 16;
    localparam int DEF_SETS    = 2;

    // What a single rank counter does on a given cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_TOP  = 2'd1,
        ACT_DOWN = 2'd2
    } rank_act_e;

    // Decide a counter's action from the reference and the rank comparison
    function automatic rank_act_e rank_action(input logic ref_v,
                                              input logic is_hit,
                                              input logic above_sel);
        if (!ref_v)         return ACT_HOLD;
        else if (is_hit)    return ACT_TOP;
        else if (above_sel) return ACT_DOWN;
        else                return ACT_HOLD;
    endfunction

endpackage

// File: rtl/lru_rank_cell.sv
module lru_rank_cell
    import lru_pkg::*;
#(
    parameter int W        = 4,
    parameter int INIT     = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_valid,
    input  logic         hit,
    input  logic [W-1:0] sel_rank,
    output logic [W-1:0] rank_q
);
    localparam logic [W-1:0] TOP  = {W{1'b1}};
    localparam logic [W-1:0] INIT_V = W'(INIT);

    rank_act_e act;

    always_comb begin
        act = rank_action(ref_valid, hit, rank_q > sel_rank);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rank_q <= INIT_V;
        end else begin
            unique case (act)
                ACT_TOP:  rank_q <= TOP;
                ACT_DOWN: rank_q <= rank_q - 1'b1;
                default:  rank_q <= rank_q;
            endcase
        end
    end

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && !hit && rank_q > sel_rank) |=> (rank_q == $past(rank_q) - 1'b1));

    // R3
    below_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && !hit && rank_q < sel_rank) |=> $stable(rank_q));

endmodule

// File: rtl/lru_min_select.sv
module lru_min_select #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0][W-1:0] ranks,
    output logic [W-1:0]        min_idx
);
    logic [W-1:0] best_rank;

    always_comb begin
        best_rank = ranks[0];
        min_idx   = '0;
        for (int i = 1; i < N; i++) begin
            if (ranks[i] < best_rank) begin
                best_rank = ranks[i];
                min_idx   = W'(i);
            end
        end
    end

endmodule

// File: rtl/lru_list.sv
module lru_list #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_valid,
    input  logic [W-1:0] ref_idx,
    output logic [W-1:0] victim
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [N-1:0][W-1:0] ranks;
    logic [W-1:0]        sel_rank;

    assign sel_rank = ranks[ref_idx];

    for (genvar i = 0; i < N; i++) begin : g_cell
        lru_rank_cell #(.W(W), .INIT(i)) cell_i (
            .clk       (clk),
            .rst       (rst),
            .ref_valid (ref_valid),
            .hit       (ref_idx == W'(i)),
            .sel_rank  (sel_rank),
            .rank_q    (ranks[i])
        );
    end

    lru_min_select #(.N(N), .W(W)) min_i (
        .ranks   (ranks),
        .min_idx (victim)
    );

    // Occupancy map of rank values, used only by the checks below
    logic [N-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) seen[ranks[i]] = 1'b1;
    end

    // R8
    perm_chk: assert property (@(posedge clk) disable iff (rst) (&seen));

    // R5
    victim_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ranks[victim] == '0));

    // R2
    hit_top_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> (ranks[$past(ref_idx)] == TOP));

    // R4
    top_ref_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && sel_rank == TOP) |=> $stable(ranks));

endmodule

// File: rtl/lru_activity_list.sv
module lru_activity_list
    import lru_pkg::*;
#(
    parameter int N_ENTRIES = DEF_ENTRIES,
    parameter int N_SETS    = DEF_SETS,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int SET_W    = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [SET_W-1:0] ref_set,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic [SET_W-1:0] query_set,
    output logic [IDX_W-1:0] victim_idx
);
    logic [N_SETS-1:0][IDX_W-1:0] victims;

    for (genvar s = 0; s < N_SETS; s++) begin : g_set
        lru_list #(.N(N_ENTRIES), .W(IDX_W)) list_i (
            .clk       (clk),
            .rst       (rst),
            .ref_valid (ref_valid && (ref_set == SET_W'(s))),
            .ref_idx   (ref_idx),
            .victim    (victims[s])
        );
    end

    assign victim_idx = victims[query_set];

endmodule

// File: tb/lru_activity_list_tb.sv
`timescale 1ns/1ps
module lru_activity_list_tb_top;
    localparam int N  = 16;
    localparam int S  = 2;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          ref_valid;
    logic [0:0]    ref_set;
    logic [IW-1:0] ref_idx;
    logic [0:0]    query_set;
    logic [IW-1:0] victim_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lru_activity_list #(.N_ENTRIES(N), .N_SETS(S)) dut_i (
        .clk, .rst, .ref_valid, .ref_set, .ref_idx, .query_set, .victim_idx
    );

    typedef struct packed {
        logic [0:0]    rset;
        logic [IW-1:0] ridx;
        logic [0:0]    qset;
        logic [IW-1:0] exp;
    } vec_t;

    // reference, then expected victim of qset after the edge
    localparam vec_t VEC [10] = '{
        '{1'd0, 4'd0, 1'd0, 4'd1},   // R2 R3
        '{1'd0, 4'd5, 1'd0, 4'd1},   // R3
        '{1'd0, 4'd1, 1'd0, 4'd2},
        '{1'd0, 4'd2, 1'd0, 4'd3},
        '{1'd0, 4'd3, 1'd0, 4'd4},
        '{1'd0, 4'd4, 1'd0, 4'd6},   // R5 skip recent 5
        '{1'd1, 4'd0, 1'd0, 4'd6},   // R7 set0 untouched
        '{1'd1, 4'd0, 1'd1, 4'd1},   // R4 top ref, set1
        '{1'd1, 4'd3, 1'd1, 4'd1},
        '{1'd0, 4'd6, 1'd0, 4'd7}
    };

    int model [S][N];

    function automatic int model_victim(int s);
        for (int i = 0; i < N; i++) if (model[s][i] == 0) return i;
        return -1;
    endfunction

    function automatic void model_ref(int s, int idx);
        int old = model[s][idx];
        for (int i = 0; i < N; i++)
            if (model[s][i] > old) model[s][i]--;
        model[s][idx] = N - 1;
    endfunction

    function automatic void model_reset();
        for (int s = 0; s < S; s++)
            for (int i = 0; i < N; i++) model[s][i] = i;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: victim %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; ref_valid = 1'b0; ref_set = '0; ref_idx = '0; query_set = '0;
        do_reset();

        // R1 reset state
        for (int s = 0; s < S; s++) begin
            query_set = 1'(s);
            #1 check("R1", victim_idx, 0);
            @(negedge clk);
        end

        // table walk
        for (int k = 0; k < 10; k++) begin
            ref_valid = 1'b1; ref_set = VEC[k].rset; ref_idx = VEC[k].ridx;
            query_set = VEC[k].qset;
            @(negedge clk);
            ref_valid = 1'b0;
            #1 check("R2/R3/R4/R5/R7 table", victim_idx, VEC[k].exp);
            @(negedge clk);
        end

        // R6 same-cycle reference and query: set0 victim is 7
        ref_valid = 1'b1; ref_set = 1'd0; ref_idx = 4'd7; query_set = 1'd0;
        #1 check("R6 pre-update", victim_idx, 7);
        @(negedge clk);
        ref_valid = 1'b0;
        #1 check("R6 post-update", victim_idx, 8);

        // R4 touch the top-ranked entry 7 again: victim unchanged
        @(negedge clk);
        ref_valid = 1'b1; ref_idx = 4'd7;
        @(negedge clk);
        ref_valid = 1'b0;
        #1 check("R4", victim_idx, 8);

        // model-driven stream
        do_reset();
        lfsr = 16'hACE1;
        for (int c = 0; c < 400; c++) begin
            ref_valid = lfsr[0] | lfsr[5];
            ref_set   = lfsr[3:3];
            ref_idx   = (lfsr[9] && ref_valid) ? IW'(model_victim(int'(lfsr[3]))) : lfsr[14:11];
            query_set = lfsr[7:7];
            #1 check("R5/R6/R8 stream", victim_idx, model_victim(int'(query_set)));
            if (ref_valid) model_ref(int'(ref_set), int'(ref_idx));
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        ref_valid = 1'b0;
        for (int s = 0; s < S; s++) begin
            query_set = 1'(s);
            #1 check("R7 stream end", victim_idx, model_victim(s));
            @(negedge clk);
        end

        // R1 reset after activity
        do_reset();
        for (int s = 0; s < S; s++) begin
            query_set = 1'(s);
            #1 check("R1 re-reset", victim_idx, 0);
            @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule